// File: doc/BRIEF.md
# Delay-Locked Loop Code Controller

This block is the digital half of a delay-locked loop. An external phase comparator looks at the delayed clock against the reference and reports, once per compare cycle, whether the delayed edge is early or late. The controller keeps an internal delay code and moves it one step per compare result until the results start alternating. Alternation means the delay line is centred on the target, and at that point the block declares lock. A run of identical results means the loop has drifted, and lock is withdrawn.

The code reaches the fine delay elements and user logic only through a published register. That register copies the internal code only while the active-low update strobe is held low, so the delay can be frozen during data transfers. Driving the strobe low while a transfer is active is a protocol error, and the block flags it. A freeze input stops the loop from acting on compares. A force-maximum input skips the search: it pins the code at full scale and marks the loop locked. Force-maximum is meant for reference clocks of about 30 MHz or slower, where the delay line cannot span a clock period. The compare port is a plain strobe with no ready signal. The block accepts a result on every cycle in which `cmp_valid` is high, so the comparator never sees back-pressure.

Top module: `dll_code_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the internal code becomes 128, the lock history and lock are cleared, `code_out` becomes 0 and `upd_violation` becomes 0.
- R2: At each clock edge where `upd_n` is low, `code_out` takes the internal code. At edges where `upd_n` is high, `code_out` keeps its value, even while the internal code moves.
- R3: `upd_violation` is high for the cycle after any edge at which `upd_n` is low and `xfer_active` is high, and is low after every other edge.
- R4: `lock` stays low until at least one publish (an edge with `upd_n` low) has happened since reset, whatever the internal lock state.
- R5: Internal lock is set by the 16th consecutive compare whose result differs from the compare before it, i.e. by the 17th compare of a strictly alternating run.
- R6: Internal lock is cleared by the 8th consecutive compare with the same result.
- R7: Each accepted compare (`cmp_valid` high) moves the internal code by +1 when `cmp_late` is 1 and by -1 when `cmp_late` is 0. The code saturates at 255 and at 0.
- R8: At an edge with `force_max` high and `freeze` low, the internal code becomes 255, internal lock is set, compares are ignored and the compare history is cleared.
- R9: At an edge with `freeze` high, the internal code, lock and compare history hold. `freeze` takes priority over compares and over `force_max`. Publishing is not affected by `freeze`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Hold the loop state |
| force_max | input | 1 | Bypass locking, pin the code at maximum |
| cmp_valid | input | 1 | A phase compare result is present this cycle |
| cmp_late | input | 1 | Compare result: 1 = late (add delay), 0 = early |
| upd_n | input | 1 | Active-low publish strobe |
| xfer_active | input | 1 | A read or write transfer is in progress |
| code_out | output | 8 | Published delay code |
| lock | output | 1 | Loop locked and the published code is valid |
| upd_violation | output | 1 | Publish strobe was seen during a transfer |

## Verification
The compare stream is driven in four shapes. Long same-direction runs show stepping and the saturation limits. Strictly alternating runs stop one compare short of the lock threshold and then reach it, which separates an off-by-one in the alternation count. A short same-direction run after lock is followed by one more compare, which pins the exact unlock threshold. Each pattern is also replayed with the publish strobe held high, with freeze set, or with force-maximum set. These runs show that the published code, the internal code and the lock state each respond only to their own controls.

// File: rtl/dll_code_pkg.sv
package dll_code_pkg;
  typedef enum logic {
    DIR_EARLY = 1'b0,
    DIR_LATE  = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/dll_code_step.sv
module dll_code_step #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              force_max,
  input  logic              step_en,
  input  logic              step_up,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_MID;
    end else if (hold) begin
      code_q <= code_q;
    end else if (force_max) begin
      code_q <= CODE_MAX;
    end else if (step_en) begin
      if (step_up) begin
        if (code_q != CODE_MAX) code_q <= code_q + CODE_W'(1);
      end else begin
        if (code_q != CODE_MIN) code_q <= code_q - CODE_W'(1);
      end
    end
  end
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det #(
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic force_max,
  input  logic step_en,
  input  logic step_up,
  output logic locked
);
  localparam int ALT_W = $clog2(LOCK_RUN + 1);
  localparam int RUN_W = $clog2(UNLOCK_RUN + 1);
  localparam logic [ALT_W-1:0] ALT_TOP = ALT_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(UNLOCK_RUN);

  logic             have_prev;
  logic             prev_up;
  logic [ALT_W-1:0] alt_q, alt_nx;
  logic [RUN_W-1:0] run_q, run_nx;
  logic             locked_nx;
  logic             flipped;
  logic             repeated;

  always_comb begin
    flipped  = have_prev && (step_up != prev_up);
    repeated = have_prev && (step_up == prev_up);
    if (flipped) alt_nx = (alt_q == ALT_TOP) ? alt_q : alt_q + ALT_W'(1);
    else         alt_nx = '0;
    if (repeated) run_nx = (run_q == RUN_TOP) ? run_q : run_q + RUN_W'(1);
    else          run_nx = RUN_W'(1);
    if (alt_nx == ALT_TOP)      locked_nx = 1'b1;
    else if (run_nx == RUN_TOP) locked_nx = 1'b0;
    else                        locked_nx = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_up   <= 1'b0;
      alt_q     <= '0;
      run_q     <= '0;
      locked    <= 1'b0;
    end else if (hold) begin
      locked <= locked;
    end else if (force_max) begin
      have_prev <= 1'b0;
      alt_q     <= '0;
      run_q     <= '0;
      locked    <= 1'b1;
    end else if (step_en) begin
      have_prev <= 1'b1;
      prev_up   <= step_up;
      alt_q     <= alt_nx;
      run_q     <= run_nx;
      locked    <= locked_nx;
    end
  end
endmodule

// File: rtl/dll_code_publish.sv
module dll_code_publish #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_n,
  input  logic              xfer_active,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              loaded,
  output logic              upd_violation
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_out      <= '0;
      loaded        <= 1'b0;
      upd_violation <= 1'b0;
    end else begin
      upd_violation <= !upd_n && xfer_active;
      if (!upd_n) begin
        code_out <= code_in;
        loaded   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl
  import dll_code_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              force_max,
  input  logic              cmp_valid,
  input  logic              cmp_late,
  input  logic              upd_n,
  input  logic              xfer_active,
  output logic [CODE_W-1:0] code_out,
  output logic              lock,
  output logic              upd_violation
);
  cmp_dir_e          dir;
  logic              step_up;
  logic [CODE_W-1:0] code_q;
  logic              locked;
  logic              loaded;

  assign dir     = cmp_dir_e'(cmp_late);
  assign step_up = (dir == DIR_LATE);

  dll_code_step #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst(rst), .hold(freeze), .force_max(force_max),
    .step_en(cmp_valid), .step_up(step_up), .code_q(code_q)
  );

  dll_lock_det #(.LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)) u_lock (
    .clk(clk), .rst(rst), .hold(freeze), .force_max(force_max),
    .step_en(cmp_valid), .step_up(step_up), .locked(locked)
  );

  dll_code_publish #(.CODE_W(CODE_W)) u_pub (
    .clk(clk), .rst(rst), .upd_n(upd_n), .xfer_active(xfer_active),
    .code_in(code_q), .code_out(code_out), .loaded(loaded),
    .upd_violation(upd_violation)
  );

  assign lock = locked && loaded;
endmodule

// File: rtl/dll_code_ctrl_chk.sv
module dll_code_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze,
  input logic              force_max,
  input logic              cmp_valid,
  input logic              cmp_late,
  input logic              upd_n,
  input logic              xfer_active,
  input logic [CODE_W-1:0] code_out,
  input logic              lock,
  input logic              upd_violation,
  input logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic seen_pub;
  always_ff @(posedge clk) begin
    if (rst) seen_pub <= 1'b0;
    else if (!upd_n) seen_pub <= 1'b1;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    upd_n |=> $stable(code_out));

  p_viol_r3: assert property (@(posedge clk) disable iff (rst)
    (!upd_n && xfer_active) |=> upd_violation);

  p_lock_valid_r4: assert property (@(posedge clk) disable iff (rst)
    lock |-> seen_pub);

  p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_late && !freeze && !force_max && code_q != CODE_MAX)
      |=> (code_q == $past(code_q) + CODE_W'(1)));

  p_sat_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_late && !freeze && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

  p_force_r8: assert property (@(posedge clk) disable iff (rst)
    (force_max && !freeze) |=> (code_q == CODE_MAX));

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(code_q));
endmodule

bind dll_code_ctrl dll_code_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .force_max(force_max),
  .cmp_valid(cmp_valid), .cmp_late(cmp_late), .upd_n(upd_n),
  .xfer_active(xfer_active), .code_out(code_out), .lock(lock),
  .upd_violation(upd_violation), .code_q(code_q)
);

// File: tb/tb_dll_code_ctrl.sv
module tb_dll_code_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       freeze = 1'b0;
  logic       force_max = 1'b0;
  logic       cmp_valid = 1'b0;
  logic       cmp_late = 1'b0;
  logic       upd_n = 1'b1;
  logic       xfer_active = 1'b0;
  logic [7:0] code_out;
  logic       lock;
  logic       upd_violation;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dll_code_ctrl dut (
    .clk(clk), .rst(rst), .freeze(freeze), .force_max(force_max),
    .cmp_valid(cmp_valid), .cmp_late(cmp_late), .upd_n(upd_n),
    .xfer_active(xfer_active), .code_out(code_out), .lock(lock),
    .upd_violation(upd_violation)
  );

  // {alternating, first_late, count[7:0], exp_code[7:0], exp_lock}
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd5,   8'd133, 1'b0},  // R7 late run
    {1'b0, 1'b0, 8'd3,   8'd130, 1'b0},  // R7 early run
    {1'b1, 1'b1, 8'd15,  8'd131, 1'b0},  // R5 one short
    {1'b1, 1'b0, 8'd1,   8'd130, 1'b1},  // R5 threshold
    {1'b0, 1'b1, 8'd7,   8'd137, 1'b1},  // R6 one short
    {1'b0, 1'b1, 8'd1,   8'd138, 1'b0},  // R6 threshold
    {1'b0, 1'b1, 8'd200, 8'd255, 1'b0},  // R7 saturate high
    {1'b0, 1'b0, 8'd3,   8'd252, 1'b0}   // R7 leave saturation
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic late);
    cmp_valid = 1'b1;
    cmp_late  = late;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic publish();
    upd_n = 1'b0;
    @(negedge clk);
    upd_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 code_out", code_out, 0);
    chk("R1 lock", lock, 0);
    chk("R1 upd_violation", upd_violation, 0);
    publish();
    chk("R1 mid-scale code", code_out, 128);

    for (int v = 0; v < NV; v++) begin
      logic dir;
      dir = VEC[v][17];
      for (int k = 0; k < int'(VEC[v][16:9]); k++) begin
        pulse(dir);
        if (VEC[v][18]) dir = ~dir;
      end
      publish();
      chk($sformatf("R7 vector %0d code", v), code_out, int'(VEC[v][8:1]));
      chk($sformatf("R5/R6 vector %0d lock", v), lock, int'(VEC[v][0]));
    end

    // R2: internal code moves, published code must not
    repeat (3) pulse(1'b1);
    chk("R2 hold while upd_n high", code_out, 252);
    publish();
    chk("R2 publish after hold", code_out, 255);

    // R3: violation flag
    xfer_active = 1'b1;
    @(negedge clk);
    chk("R3 xfer without strobe", upd_violation, 0);
    upd_n = 1'b0;
    @(negedge clk);
    upd_n = 1'b1;
    chk("R3 strobe during xfer", upd_violation, 1);
    xfer_active = 1'b0;
    @(negedge clk);
    chk("R3 flag clears", upd_violation, 0);

    // R9: freeze holds the code and beats force_max
    freeze = 1'b1;
    repeat (5) pulse(1'b0);
    force_max = 1'b1;
    @(negedge clk);
    force_max = 1'b0;
    freeze = 1'b0;
    publish();
    chk("R9 frozen code", code_out, 255);
    chk("R9 lock held low", lock, 0);

    // R7 low saturation
    do_reset();
    repeat (130) pulse(1'b0);
    publish();
    chk("R7 saturate low", code_out, 0);
    chk("R6 no lock on long run", lock, 0);

    // R8 and R4: force max, lock gated by publish
    do_reset();
    force_max = 1'b1;
    repeat (3) pulse(1'b0);
    chk("R4 lock gated before publish", lock, 0);
    chk("R2 code_out before publish", code_out, 0);
    publish();
    chk("R8 forced code", code_out, 255);
    chk("R8 forced lock", lock, 1);
    force_max = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule